// File: doc/BRIEF.md
# I2C SCL Waveform Generator

This block produces the serial clock level for an I2C master from the system clock. A waveform word carries a power-of-two prescale exponent and separate dividers for the high and low halves of the SCL period. The exponent is shared by both halves. Each half lasts the divider scaled by two to the exponent, plus a fixed number of system clocks that a build parameter sets. The exponent is clipped to a build-time ceiling. Software works out the divider values for a target bus rate. Slave clock stretching is not handled here.

The transfer engine holds `enable` low while the bus is idle. In that state SCL stays high and the phase timer is kept cleared. Raising `enable` begins a complete low half. After that the halves alternate. A one-cycle marker is raised in the final cycle of every low half and in the final cycle of every high half, so the engine can shift data on the marker. A write of the waveform word never cuts short or lengthens the half that is already running. The new timing applies to the first half that begins after the write. The block carries no data stream, so all of its pins are plain control and status signals with no valid/ready handshake.

Top module: `scl_wavegen`

## Requirements
- R1: While `enable` is low, `scl_o` is 1 and both `low_end_o` and `high_end_o` are 0 from the cycle after `enable` was sampled low.
- R2: On the first clock edge with `enable` high after being low, `scl_o` goes to 0, and that first low half has the full programmed length.
- R3: A low half lasts low_div × 2^e + OFFSET system clocks. low_div is bits 7:0 of `cfg_data` and e is the effective exponent.
- R4: A high half lasts high_div × 2^e + OFFSET system clocks. high_div is bits 15:8 of `cfg_data`.
- R5: The exponent is bits 18:16 of `cfg_data`. A written exponent above MAX_EXP is used as MAX_EXP.
- R6: A word presented with `cfg_wr` high is captured at that clock edge. It governs only halves that start at a later edge, and the half in progress keeps its length.
- R7: `low_end_o` is high exactly in the last cycle of each low half, and `high_end_o` is high exactly in the last cycle of each high half. The two are never high together.
- R8: Dropping `enable` in the middle of a half returns `scl_o` to 1 on the next cycle. A later re-enable starts a fresh, full low half.
- R9: A divider of 0 gives a half of exactly OFFSET system clocks. A divider of 255 with the top exponent gives 255 × 2^MAX_EXP + OFFSET.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| enable | input | 1 | Run the waveform; low holds SCL high and clears the timer |
| cfg_wr | input | 1 | Write strobe for the waveform word |
| cfg_data | input | 19 | Waveform word: exponent [18:16], high divider [15:8], low divider [7:0] |
| scl_o | output | 1 | SCL level |
| low_end_o | output | 1 | Marker in the final cycle of a low half |
| high_end_o | output | 1 | Marker in the final cycle of a high half |

## Verification
`scl_o` changes one edge after the stimulus that causes it: one edge after `enable` is sampled, and one edge after the final cycle of a half. The end markers are decoded from timer state, so each one is visible in the final cycle of its half. The bench drives inputs and samples outputs on falling edges, and it measures a half as the number of falling-edge samples that show the same level. After a mid-run write, the bench throws away the partial half and the half after it before it compares lengths. The one exception is a directed case that writes well inside a half, which checks that the running half keeps its old remaining length and that the following half uses the new word.

// File: rtl/scl_wavegen_pkg.sv
package scl_wavegen_pkg;
  localparam int DIV_W     = 8;
  localparam int EXP_W     = 3;
  localparam int WORD_W    = 2 * DIV_W + EXP_W;
  localparam int LO_LSB    = 0;
  localparam int HI_LSB    = DIV_W;
  localparam int EXP_LSB   = 2 * DIV_W;

  typedef struct packed {
    logic [EXP_W-1:0] expo;
    logic [DIV_W-1:0] hi_div;
    logic [DIV_W-1:0] lo_div;
  } wave_cfg_t;

  function automatic logic [EXP_W-1:0] clip_exp(input logic [EXP_W-1:0] e,
                                                input int unsigned ceil_v);
    if (int'(e) > int'(ceil_v)) return EXP_W'(ceil_v);
    return e;
  endfunction
endpackage

// File: rtl/scl_cfg_hold.sv
module scl_cfg_hold
  import scl_wavegen_pkg::*;
#(
  parameter int OFFSET  = 4,
  parameter int MAX_EXP = 5,
  parameter int LEN_W   = 14
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr,
  input  logic [WORD_W-1:0] word,
  output logic [LEN_W-1:0]  len_lo,
  output logic [LEN_W-1:0]  len_hi
);
  wave_cfg_t cfg_q;
  wave_cfg_t cfg_in;

  always_comb begin
    cfg_in        = wave_cfg_t'(word);
    cfg_in.expo   = clip_exp(cfg_in.expo, MAX_EXP);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  cfg_q <= '0;
    else if (wr) cfg_q <= cfg_in;
  end

  logic [DIV_W-1:0] div_sel [2];
  logic [LEN_W-1:0] len_sel [2];
  assign div_sel[0] = cfg_q.lo_div;
  assign div_sel[1] = cfg_q.hi_div;

  for (genvar g = 0; g < 2; g++) begin : g_len
    always_comb
      len_sel[g] = (LEN_W'(div_sel[g]) << cfg_q.expo) + LEN_W'(OFFSET);
  end

  assign len_lo = len_sel[0];
  assign len_hi = len_sel[1];
endmodule

// File: rtl/scl_phase_timer.sv
module scl_phase_timer #(
  parameter int LEN_W = 14
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             enable,
  input  logic [LEN_W-1:0] len_lo,
  input  logic [LEN_W-1:0] len_hi,
  output logic             scl,
  output logic             lo_end,
  output logic             hi_end
);
  logic             running;
  logic [LEN_W-1:0] cnt;
  logic             last;

  assign last   = running && (cnt == '0);
  assign lo_end = last && !scl;
  assign hi_end = last && scl;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      running <= 1'b0;
      scl     <= 1'b1;
      cnt     <= '0;
    end else if (!enable) begin
      running <= 1'b0;
      scl     <= 1'b1;
      cnt     <= '0;
    end else if (!running) begin
      running <= 1'b1;
      scl     <= 1'b0;
      cnt     <= len_lo - LEN_W'(1);
    end else if (last) begin
      scl     <= !scl;
      cnt     <= (scl ? len_lo : len_hi) - LEN_W'(1);
    end else begin
      cnt     <= cnt - LEN_W'(1);
    end
  end
endmodule

// File: rtl/scl_wavegen.sv
module scl_wavegen
  import scl_wavegen_pkg::*;
#(
  parameter int OFFSET  = 4,
  parameter int MAX_EXP = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              enable,
  input  logic              cfg_wr,
  input  logic [WORD_W-1:0] cfg_data,
  output logic              scl_o,
  output logic              low_end_o,
  output logic              high_end_o
);
  localparam int MAX_LEN = ((1 << DIV_W) - 1) * (1 << MAX_EXP) + OFFSET;
  localparam int LEN_W   = $clog2(MAX_LEN + 1);

  logic [LEN_W-1:0] len_lo, len_hi;

  scl_cfg_hold #(.OFFSET(OFFSET), .MAX_EXP(MAX_EXP), .LEN_W(LEN_W)) u_cfg (
    .clk(clk), .rst_n(rst_n), .wr(cfg_wr), .word(cfg_data),
    .len_lo(len_lo), .len_hi(len_hi)
  );

  scl_phase_timer #(.LEN_W(LEN_W)) u_timer (
    .clk(clk), .rst_n(rst_n), .enable(enable),
    .len_lo(len_lo), .len_hi(len_hi),
    .scl(scl_o), .lo_end(low_end_o), .hi_end(high_end_o)
  );
endmodule

// File: rtl/scl_wavegen_checker.sv
module scl_wavegen_checker (
  input logic clk,
  input logic rst_n,
  input logic enable,
  input logic scl_o,
  input logic low_end_o,
  input logic high_end_o
);
  assert_idle_high_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !enable |=> (scl_o && !low_end_o && !high_end_o));

  assert_start_low_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(enable) |=> !scl_o);

  assert_low_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (enable && !scl_o && !low_end_o) |=> !scl_o);

  assert_ticks_exclusive_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !(low_end_o && high_end_o));

  assert_low_tick_level_R7: assert property (@(posedge clk) disable iff (!rst_n)
    low_end_o |-> !scl_o);

  assert_high_tick_level_R7: assert property (@(posedge clk) disable iff (!rst_n)
    high_end_o |-> scl_o);

  assert_low_to_high_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (low_end_o && enable) |=> scl_o);

  assert_high_to_low_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (high_end_o && enable) |=> !scl_o);
endmodule

bind scl_wavegen scl_wavegen_checker u_chk (
  .clk(clk), .rst_n(rst_n), .enable(enable), .scl_o(scl_o),
  .low_end_o(low_end_o), .high_end_o(high_end_o)
);

// File: tb/scl_wavegen_bench.sv
module scl_wavegen_bench;
  localparam int OFFSET  = 4;
  localparam int MAX_EXP = 5;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        enable = 1'b0;
  logic        cfg_wr = 1'b0;
  logic [18:0] cfg_data = '0;
  logic        scl_o, low_end_o, high_end_o;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #4 clk = ~clk;

  scl_wavegen #(.OFFSET(OFFSET), .MAX_EXP(MAX_EXP)) u_scl_wavegen (
    .clk(clk), .rst_n(rst_n), .enable(enable), .cfg_wr(cfg_wr),
    .cfg_data(cfg_data), .scl_o(scl_o), .low_end_o(low_end_o),
    .high_end_o(high_end_o)
  );

  function automatic int exp_len(input int dv, input int e);
    int ee = (e > MAX_EXP) ? MAX_EXP : e;
    return dv * (1 << ee) + OFFSET;
  endfunction

  task automatic check(input bit ok, input string tag, input int act, input int expv);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, expv);
    end
  endtask

  task automatic write_cfg(input int e, input int hi, input int lo);
    cfg_data = {3'(e), 8'(hi), 8'(lo)};
    cfg_wr   = 1'b1;
    @(negedge clk);
    cfg_wr   = 1'b0;
  endtask

  // Measures the half that is visible at the current falling edge.
  task automatic measure(output bit lvl, output int len, output bit tick_ok);
    int ticks = 0;
    bit last_ok = 1'b0;
    lvl = scl_o;
    len = 0;
    while (scl_o == lvl && len < 70000) begin
      ticks  += int'(low_end_o) + int'(high_end_o);
      last_ok = lvl ? high_end_o : low_end_o;
      @(negedge clk);
      len++;
    end
    tick_ok = (ticks == 1) && last_ok;
  endtask

  task automatic check_pair(input int e, input int hi, input int lo, input string tag);
    bit l; int n; bit t;
    for (int k = 0; k < 2; k++) begin
      measure(l, n, t);
      if (l) check(n == exp_len(hi, e), {tag, " R4 high len"}, n, exp_len(hi, e));
      else   check(n == exp_len(lo, e), {tag, " R3 low len"}, n, exp_len(lo, e));
      check(t, {tag, " R7 tick"}, int'(t), 1);
    end
  endtask

  initial begin : main
    bit l; int n; bit t;
    void'($urandom(32'd4242));
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check(scl_o && !low_end_o && !high_end_o, "R1 reset idle", int'(scl_o), 1);

    // Directed: program while idle, then enable.
    write_cfg(1, 9, 5);
    repeat (3) @(negedge clk);
    check(scl_o == 1'b1, "R1 idle after write", int'(scl_o), 1);
    enable = 1'b1;
    @(negedge clk);
    check(scl_o == 1'b0, "R2 first half low", int'(scl_o), 0);
    measure(l, n, t);
    check(n == 14, "R2 full first low", n, 14);
    check(t, "R7 first low tick", int'(t), 1);
    measure(l, n, t);
    check(l && n == 22, "R4 high 9x2+4", n, 22);
    check(t, "R7 high tick", int'(t), 1);

    // R6: write three cycles into a low half.
    repeat (2) @(negedge clk);
    write_cfg(0, 2, 20);
    measure(l, n, t);
    check(!l && n == 11, "R6 running half kept", n, 11);
    measure(l, n, t);
    check(l && n == 6, "R6 next high uses new word", n, 6);
    measure(l, n, t);
    check(!l && n == 24, "R6 next low uses new word", n, 24);

    // R5 saturation.
    write_cfg(7, 1, 3);
    measure(l, n, t); measure(l, n, t);
    check_pair(7, 1, 3, "R5 exp7");
    write_cfg(6, 2, 0);
    measure(l, n, t); measure(l, n, t);
    check_pair(6, 2, 0, "R5 exp6");

    // R9 zero dividers and maximum.
    write_cfg(3, 0, 0);
    measure(l, n, t); measure(l, n, t);
    check_pair(3, 0, 0, "R9 zero");
    write_cfg(MAX_EXP, 255, 255);
    measure(l, n, t); measure(l, n, t);
    check_pair(MAX_EXP, 255, 255, "R9 max");

    // R8: drop enable mid-half.
    write_cfg(2, 3, 6);
    measure(l, n, t);
    repeat (5) @(negedge clk);
    enable = 1'b0;
    @(negedge clk);
    check(scl_o == 1'b1, "R8 scl high after disable", int'(scl_o), 1);
    for (int k = 0; k < 6; k++) begin
      check(scl_o && !low_end_o && !high_end_o, "R1 idle no ticks", int'(low_end_o | high_end_o), 0);
      @(negedge clk);
    end
    enable = 1'b1;
    @(negedge clk);
    check(scl_o == 1'b0, "R8 restart low", int'(scl_o), 0);
    measure(l, n, t);
    check(n == exp_len(6, 2), "R8 fresh full low", n, exp_len(6, 2));

    // Constrained random.
    for (int it = 0; it < 8; it++) begin
      int e  = int'($urandom_range(7, 0));
      int hi = int'($urandom_range(31, 0));
      int lo = int'($urandom_range(31, 0));
      write_cfg(e, hi, lo);
      measure(l, n, t); measure(l, n, t);
      check_pair(e, hi, lo, "RND R3 R4");
    end

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin : watchdog
    repeat (190000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog expired actual=0 expected=1");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule